// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches eight synchronised input pins and turns selected pin activity into interrupt requests. Software sets up each pin through a byte-wide register bus. One bit picks whether the pin reacts to a level or to an edge. A second bit picks the active sense: high level or rising edge, versus low level or falling edge. A per-pin enable gates the request, and an optional glitch filter can be switched in for each pin.

Edge events are held in a per-pin pending latch until software writes a one to that pin's bit in the acknowledge register. A level request follows the pin and needs no acknowledge. The block offers the enabled requests in two forms: a per-pin request vector, for systems that route one interrupt per pin, and a single combined line. The same byte can also be read back over the bus.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is low and right after it, every register reads 0, `irqVec` is 0 and `irqOut` is 0. All pins come out disabled, level-sensitive, active-low and unfiltered.
- R2: The mode register sits at 0x90, with bit i = 1 for edge and 0 for level. The sense register sits at 0x94, with bit i = 1 for high/rising and 0 for low/falling. The enable register sits at 0x9C and the filter-enable register at 0xA8. Each of these reads back the value last written. The acknowledge register at 0x98 reads 0.
- R3: A level-mode, enabled, unfiltered pin shows its request bit exactly while the pin equals its sense bit. The bit drops as soon as the pin leaves the active level.
- R4: An edge-mode, enabled pin latches a request on the selected edge, seen one clock after the pin changes. The request stays set after the pin returns.
- R5: Writing byte d to 0x98 clears the latched edge request of each pin whose bit in d is 1. Pins whose bit is 0 keep their request.
- R6: When an active edge and an acknowledge for the same pin fall in the same cycle, the request stays set.
- R7: A pin whose enable bit is 0 never shows a request. Its latch is cleared while it is disabled. Changing mode or sense while the pin is disabled leaves no request once it is enabled again.
- R8: An acknowledge write has no effect on a level-mode pin.
- R9: With filtering on, a new pin value reaches detection only after it has been present on three consecutive filter ticks. A return to the old value restarts the count. With filtering off, the pin reaches detection at once.
- R10: The status byte at 0xA0 equals `irqVec`, and `irqOut` is 1 exactly when any bit of `irqVec` is 1.
- R11: Reads from addresses with no register return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Register byte address |
| regWr | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| pinIn | input | 8 | Synchronised pin levels |
| dbTick | input | 1 | Filter sample tick |
| irqOut | output | 1 | Combined interrupt request |
| irqVec | output | 8 | Per-pin interrupt requests |

## Verification
An active edge on a pin and the acknowledge write for that same pin can land on one clock edge. When they do, the latch has to choose between setting and clearing. The bench provokes this by first leaving a latched rising-edge request on pin 0, then driving the next rise of that pin in the very cycle that the acknowledge strobe carries bit 0. A correct block still shows the request afterward, and a following lone acknowledge must clear it. Together these show that the set has priority and that the clear itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  parameter int ADDR_W = 8;

  parameter logic [ADDR_W-1:0] OFF_MODE  = 8'h90;
  parameter logic [ADDR_W-1:0] OFF_SENSE = 8'h94;
  parameter logic [ADDR_W-1:0] OFF_ACK   = 8'h98;
  parameter logic [ADDR_W-1:0] OFF_EN    = 8'h9C;
  parameter logic [ADDR_W-1:0] OFF_STAT  = 8'hA0;
  parameter logic [ADDR_W-1:0] OFF_FILT  = 8'hA8;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_SENSE, RD_EN, RD_FILT, RD_STAT
  } rdSel_t;

  typedef struct packed {
    logic   wrMode;
    logic   wrSense;
    logic   wrAck;
    logic   wrEn;
    logic   wrFilt;
    rdSel_t rdSel;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    case (regAddr)
      OFF_MODE:  begin strobe.wrMode  = regWr; strobe.rdSel = RD_MODE;  end
      OFF_SENSE: begin strobe.wrSense = regWr; strobe.rdSel = RD_SENSE; end
      OFF_ACK:   begin strobe.wrAck   = regWr; strobe.rdSel = RD_NONE;  end
      OFF_EN:    begin strobe.wrEn    = regWr; strobe.rdSel = RD_EN;    end
      OFF_FILT:  begin strobe.wrFilt  = regWr; strobe.rdSel = RD_FILT;  end
      OFF_STAT:  strobe.rdSel = RD_STAT;
      default:   strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int DB_TICKS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  input  logic tick,
  input  logic enable,
  output logic filt
);
  localparam int CNT_W = $clog2(DB_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (!enable) begin
      filt <= raw;
      cnt  <= '0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        filt <= raw;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DB_TICKS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                dbTick,
  output logic [NUM_PINS-1:0] rdata,
  output logic [NUM_PINS-1:0] irqVec
);
  logic [NUM_PINS-1:0] modeQ, senseQ, enQ, filtEnQ, pendQ, prevQ;
  logic [NUM_PINS-1:0] filtVal, detVal, edgeHit, levelHit, ackMask, edgeArm;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_irq_filter #(.DB_TICKS(DB_TICKS)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .raw    (pinIn[i]),
      .tick   (dbTick),
      .enable (filtEnQ[i]),
      .filt   (filtVal[i])
    );
  end

  always_comb begin
    detVal   = (filtEnQ & filtVal) | (~filtEnQ & pinIn);
    edgeHit  = (senseQ & detVal & ~prevQ) | (~senseQ & ~detVal & prevQ);
    levelHit = ~(detVal ^ senseQ);
    ackMask  = strobe.wrAck ? wdata : '0;
    edgeArm  = modeQ & enQ;
    irqVec   = enQ & ((modeQ & pendQ) | (~modeQ & levelHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= '0;
      senseQ  <= '0;
      enQ     <= '0;
      filtEnQ <= '0;
      pendQ   <= '0;
      prevQ   <= '0;
    end else begin
      if (strobe.wrMode)  modeQ   <= wdata;
      if (strobe.wrSense) senseQ  <= wdata;
      if (strobe.wrEn)    enQ     <= wdata;
      if (strobe.wrFilt)  filtEnQ <= wdata;
      prevQ <= detVal;
      pendQ <= ((pendQ & ~ackMask) | edgeHit) & edgeArm;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_MODE:  rdata = modeQ;
      RD_SENSE: rdata = senseQ;
      RD_EN:    rdata = enQ;
      RD_FILT:  rdata = filtEnQ;
      RD_STAT:  rdata = irqVec;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DB_TICKS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWr,
  input  logic [NUM_PINS-1:0] regWdata,
  output logic [NUM_PINS-1:0] regRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                dbTick,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] irqVec
);
  regStrobe_t strobe;

  gpio_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .strobe  (strobe)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .DB_TICKS(DB_TICKS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (regWdata),
    .pinIn  (pinIn),
    .dbTick (dbTick),
    .rdata  (regRdata),
    .irqVec (irqVec)
  );

  assign irqOut = |irqVec;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWr,
  input logic [NUM_PINS-1:0] regWdata,
  input logic [NUM_PINS-1:0] regRdata,
  input logic [NUM_PINS-1:0] pinIn,
  input logic                dbTick,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] irqVec
);
  logic [NUM_PINS-1:0] modeS, senseS, enS, filtS, levelMask, edgeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeS  <= '0;
      senseS <= '0;
      enS    <= '0;
      filtS  <= '0;
    end else if (regWr) begin
      if (regAddr == OFF_MODE)  modeS  <= regWdata;
      if (regAddr == OFF_SENSE) senseS <= regWdata;
      if (regAddr == OFF_EN)    enS    <= regWdata;
      if (regAddr == OFF_FILT)  filtS  <= regWdata;
    end
  end

  assign levelMask = enS & ~modeS & ~filtS;
  assign edgeMask  = enS & modeS;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!irqOut && irqVec == '0));

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((irqVec ^ ~(pinIn ^ senseS)) & levelMask) == '0);

  assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> (($past(irqVec) & $past(edgeMask) & ~irqVec) == '0));

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqVec & ~enS) == '0);

  assert_status_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_STAT) |-> (regRdata == irqVec));
endmodule

bind gpio_irq_port gpio_irq_checker #(.NUM_PINS(NUM_PINS)) i_chk (.*);

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [7:0] pinIn = 8'h00;
  logic       dbTick = 1'b0;
  logic       irqOut;
  logic [7:0] irqVec;

  int checks = 0;
  int failures = 0;

  localparam logic [7:0] A_MODE = 8'h90, A_SENSE = 8'h94, A_ACK = 8'h98,
                         A_EN = 8'h9C, A_STAT = 8'hA0, A_FILT = 8'hA8;

  always #10 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .dbTick(dbTick), .irqOut(irqOut), .irqVec(irqVec)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 8'h00;
    #1;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdata;
    regAddr = 8'h00;
  endtask

  task automatic setPins(logic [7:0] p);
    @(negedge clk);
    pinIn = p;
    settle();
  endtask

  task automatic tick();
    @(negedge clk); dbTick = 1'b1;
    @(negedge clk); dbTick = 1'b0;
    #1;
  endtask

  task automatic clearCfg();
    wrReg(A_EN, 8'h00);
    wrReg(A_MODE, 8'h00);
    wrReg(A_SENSE, 8'h00);
    wrReg(A_FILT, 8'h00);
    wrReg(A_ACK, 8'hFF);
    setPins(8'h00);
    settle();
  endtask

  task automatic testReset();
    logic [7:0] v;
    #1;
    check("R1 vec in reset", irqVec, 8'h00);
    check("R1 line in reset", {7'b0, irqOut}, 8'h00);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    settle();
    rdReg(A_MODE, v);  check("R1 mode", v, 8'h00);
    rdReg(A_SENSE, v); check("R1 sense", v, 8'h00);
    rdReg(A_EN, v);    check("R1 enable", v, 8'h00);
    rdReg(A_FILT, v);  check("R1 filter", v, 8'h00);
    rdReg(A_STAT, v);  check("R1 status", v, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] v;
    wrReg(A_MODE, 8'hA5);  rdReg(A_MODE, v);  check("R2 mode rw", v, 8'hA5);
    wrReg(A_SENSE, 8'h3C); rdReg(A_SENSE, v); check("R2 sense rw", v, 8'h3C);
    wrReg(A_FILT, 8'h81);  rdReg(A_FILT, v);  check("R2 filter rw", v, 8'h81);
    wrReg(A_EN, 8'h00);    rdReg(A_EN, v);    check("R2 enable rw", v, 8'h00);
    wrReg(A_ACK, 8'hFF);   rdReg(A_ACK, v);   check("R2 ack reads 0", v, 8'h00);
    wrReg(8'h00, 8'hFF);
    rdReg(8'h00, v);   check("R11 unmapped read", v, 8'h00);
    rdReg(A_MODE, v);  check("R11 mode untouched", v, 8'hA5);
    rdReg(A_SENSE, v); check("R11 sense untouched", v, 8'h3C);
    clearCfg();
  endtask

  task automatic testLevel();
    wrReg(A_SENSE, 8'h80);
    wrReg(A_EN, 8'hC0);
    settle();
    check("R3 low-active pin6 at 0", irqVec, 8'h40);
    setPins(8'h40);
    check("R3 pin6 leaves level", irqVec, 8'h00);
    setPins(8'hC0);
    check("R3 high-active pin7", irqVec, 8'h80);
    check("R10 line set", {7'b0, irqOut}, 8'h01);
    setPins(8'h40);
    check("R3 pin7 drops at once", irqVec, 8'h00);
    clearCfg();
  endtask

  task automatic testEdge();
    logic [7:0] v;
    setPins(8'h20);
    wrReg(A_MODE, 8'h30);
    wrReg(A_SENSE, 8'h10);
    wrReg(A_EN, 8'h30);
    settle();
    check("R4 no event yet", irqVec, 8'h00);
    setPins(8'h30);
    check("R4 rising pin4 latched", irqVec, 8'h10);
    setPins(8'h20);
    check("R4 held after fall", irqVec, 8'h10);
    setPins(8'h00);
    check("R4 falling pin5 latched", irqVec, 8'h30);
    rdReg(A_STAT, v);
    check("R10 status read", v, 8'h30);
    wrReg(A_ACK, 8'h10);
    check("R5 ack pin4 only", irqVec, 8'h20);
    wrReg(A_ACK, 8'h20);
    check("R5 ack pin5", irqVec, 8'h00);
    check("R10 line clear", {7'b0, irqOut}, 8'h00);
    clearCfg();
  endtask

  task automatic testCollide();
    wrReg(A_MODE, 8'h01);
    wrReg(A_SENSE, 8'h01);
    wrReg(A_EN, 8'h01);
    setPins(8'h01);
    setPins(8'h00);
    check("R6 pre-latched", irqVec, 8'h01);
    @(negedge clk);
    pinIn = 8'h01; regAddr = A_ACK; regWdata = 8'h01; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 8'h00;
    #1;
    check("R6 edge beats ack", irqVec, 8'h01);
    wrReg(A_ACK, 8'h01);
    check("R5 lone ack clears", irqVec, 8'h00);
    clearCfg();
  endtask

  task automatic testDisable();
    wrReg(A_MODE, 8'h04);
    wrReg(A_SENSE, 8'h04);
    setPins(8'h04);
    check("R7 disabled edge hidden", irqVec, 8'h00);
    wrReg(A_EN, 8'h04);
    check("R7 no stale event", irqVec, 8'h00);
    setPins(8'h00);
    setPins(8'h04);
    check("R7 enabled edge seen", irqVec, 8'h04);
    wrReg(A_EN, 8'h00);
    check("R7 disabled hides", irqVec, 8'h00);
    wrReg(A_SENSE, 8'h00);
    wrReg(A_MODE, 8'h00);
    wrReg(A_MODE, 8'h04);
    wrReg(A_EN, 8'h04);
    check("R7 reenable clean", irqVec, 8'h00);
    clearCfg();
  endtask

  task automatic testLevelAck();
    wrReg(A_SENSE, 8'h08);
    wrReg(A_EN, 8'h08);
    setPins(8'h08);
    check("R8 level active", irqVec, 8'h08);
    wrReg(A_ACK, 8'h08);
    check("R8 ack ignored", irqVec, 8'h08);
    setPins(8'h00);
    check("R8 level gone", irqVec, 8'h00);
    clearCfg();
  endtask

  task automatic testFilter();
    wrReg(A_SENSE, 8'h02);
    wrReg(A_FILT, 8'h02);
    wrReg(A_EN, 8'h02);
    setPins(8'h02);
    check("R9 blocked before ticks", irqVec, 8'h00);
    tick(); tick();
    check("R9 two ticks short", irqVec, 8'h00);
    setPins(8'h00);
    tick();
    setPins(8'h02);
    tick(); tick();
    check("R9 glitch restarts", irqVec, 8'h00);
    tick();
    settle();
    check("R9 third tick passes", irqVec, 8'h02);
    wrReg(A_FILT, 8'h00);
    setPins(8'h00);
    check("R9 unfiltered immediate", irqVec, 8'h00);
    clearCfg();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testRegs();
    testLevel();
    testEdge();
    testCollide();
    testDisable();
    testLevelAck();
    testFilter();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule